// File: doc/BRIEF.md
# Pause Frame Receive Filter

This block sits in the receive path of an Ethernet MAC, between the frame decoder and the receive client. It looks at the header of every incoming frame. A frame counts as a standard pause control frame when its length/type field and its MAC control opcode have the pause values. For such a frame the block checks whether the destination address equals a programmable 48-bit address or the reserved pause multicast address. A matching pause frame can raise a one-cycle pause request, carrying the 16-bit pause quanta, toward the transmit side. The block also decides whether that frame reaches the client or is removed from the stream.

Frames enter and leave as 64-bit AXI4-Stream style beats with a byte-keep mask and a last flag. Byte 0 of the frame is carried in `s_data[7:0]`. Every beat crosses a three-stage delay line, so the forward or drop decision can be made before the first beat leaves. A forwarded frame comes out unchanged and without gaps. A dropped frame produces no output beats at all.

Three small registers set the behaviour. They are written through a simple write strobe with a select code. One holds the low 32 bits of the match address. One holds its high 16 bits. One holds three enables: processing, pass-through and transmit response.

Top module: `pfx_top`

## Requirements
- R1: A frame is a pause frame only when bytes 12..13 hold 0x88,0x08 (type 0x8808) and bytes 14..15 hold 0x00,0x01 (opcode 0x0001). Any other type or opcode is forwarded and raises no request.
- R2: The destination address is frame bytes 0..5, with byte 0 compared against address bit 47..40. It matches when it equals {high register[15:0], low register[31:0]}.
- R3: The destination 01-80-C2-00-00-01 also matches, whatever address is programmed.
- R4: Registers are written when `cfg_we` is 1. Select 0 writes the low address word and select 1 writes the high address half. Select 2 writes the control word: bit 0 is the processing enable, bit 1 the pass-through enable and bit 2 the transmit-response enable. After reset the control word is processing=1, pass-through=0, transmit-response=1.
- R5: With processing disabled, a matching pause frame is dropped and raises no request, whatever the pass-through bit is.
- R6: With processing and transmit response enabled, a matching pause frame raises `pause_req` for exactly one cycle. This happens in the cycle after its third beat is accepted. `pause_quanta` then holds bytes 16..17 of the frame, with byte 16 as the high byte.
- R7: With processing enabled, a matching pause frame is dropped when pass-through is 0 and forwarded unchanged when pass-through is 1.
- R8: A pause frame whose destination does not match is always forwarded and raises no request.
- R9: With transmit response disabled, no request is raised. The frame is still dropped or forwarded as R5 and R7 say.
- R10: A frame that ends before both quanta bytes are present is forwarded unchanged and raises no request. Such a frame is one that ends in its first or second beat, or whose third beat has keep bit 1 clear.
- R11: Every forwarded beat appears on the output exactly three cycles after it was accepted, with its data, keep and last unchanged. Back-to-back frames keep their own decisions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 address low, 1 address high, 2 control |
| cfg_wdata | input | 32 | Register write data |
| s_valid | input | 1 | Input beat valid; held high from first to last beat of a frame |
| s_data | input | 64 | Input beat data, frame byte 0 in bits 7..0 |
| s_keep | input | 8 | Input byte-keep mask |
| s_last | input | 1 | Input last beat of frame |
| m_valid | output | 1 | Output beat valid |
| m_data | output | 64 | Output beat data |
| m_keep | output | 8 | Output byte-keep mask |
| m_last | output | 1 | Output last beat of frame |
| pause_req | output | 1 | One-cycle pause request toward the transmitter |
| pause_quanta | output | 16 | Pause quanta of the latest request |

## Verification
The filter is driven with frames that differ in one field at a time. These are a programmed unicast address, the reserved multicast address, an unrelated unicast address, a non-control type and a control type with a different opcode. Each variant shows that the address, type and opcode tests act independently. Each enable combination is then applied to the same matching frame, which separates the drop decision from the request gating. Frames cut short at the first, second and third beat probe the header-length rule. Chained frames with no idle cycle between them show that a decision never spills into a neighbouring frame.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
    localparam int BEAT_BYTES = 8;
    localparam int BEAT_W     = BEAT_BYTES * 8;
    localparam int ADDR_W     = 48;
    localparam int STAGES     = 3;

    localparam logic [15:0]       CTL_TYPE   = 16'h8808;
    localparam logic [15:0]       PAUSE_OPC  = 16'h0001;
    localparam logic [ADDR_W-1:0] PAUSE_MCST = 48'h0180C2000001;

    typedef enum logic [1:0] {
        SEL_ADDR_LO = 2'd0,
        SEL_ADDR_HI = 2'd1,
        SEL_CTRL    = 2'd2
    } cfg_sel_e;

    typedef struct packed {
        logic                  valid;
        logic                  drop;
        logic                  last;
        logic [BEAT_BYTES-1:0] keep;
        logic [BEAT_W-1:0]     data;
    } beat_t;
endpackage

// File: rtl/pfx_classify.sv
module pfx_classify
    import pfx_pkg::*;
(
    input  logic [47:0]       hdr0,
    input  logic [63:32]      hdr1,
    input  logic [15:0]       hdr2,
    input  logic              hdr2_keep1,
    input  logic [ADDR_W-1:0] match_addr,
    output logic              is_pause,
    output logic              addr_hit,
    output logic              full_hdr,
    output logic [15:0]       quanta
);
    localparam int DA_BYTES = ADDR_W / 8;

    logic [ADDR_W-1:0] dest;
    logic [15:0]       ltype;
    logic [15:0]       opcode;

    always_comb begin
        for (int k = 0; k < DA_BYTES; k++) begin
            dest[ADDR_W-1-8*k -: 8] = hdr0[8*k +: 8];
        end
        ltype    = {hdr1[39:32], hdr1[47:40]};
        opcode   = {hdr1[55:48], hdr1[63:56]};
        quanta   = {hdr2[7:0], hdr2[15:8]};
        is_pause = (ltype == CTL_TYPE) && (opcode == PAUSE_OPC);
        addr_hit = (dest == match_addr) || (dest == PAUSE_MCST);
        full_hdr = hdr2_keep1;
    end
endmodule

// File: rtl/pfx_policy.sv
module pfx_policy (
    input  logic is_pause,
    input  logic addr_hit,
    input  logic full_hdr,
    input  logic proc_en,
    input  logic fwd_en,
    input  logic tx_en,
    output logic drop,
    output logic req
);
    logic hit;

    always_comb begin
        hit  = full_hdr && is_pause && addr_hit;
        drop = hit && !(proc_en && fwd_en);
        req  = hit && proc_en && tx_en;
    end
endmodule

// File: rtl/pfx_top.sv
module pfx_top
    import pfx_pkg::*;
#(
    parameter logic [ADDR_W-1:0] ADDR_RST = '0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [1:0]            cfg_sel,
    input  logic [31:0]           cfg_wdata,
    input  logic                  s_valid,
    input  logic [BEAT_W-1:0]     s_data,
    input  logic [BEAT_BYTES-1:0] s_keep,
    input  logic                  s_last,
    output logic                  m_valid,
    output logic [BEAT_W-1:0]     m_data,
    output logic [BEAT_BYTES-1:0] m_keep,
    output logic                  m_last,
    output logic                  pause_req,
    output logic [15:0]           pause_quanta
);
    localparam int LAST_ST  = STAGES - 1;
    localparam int IDX_W    = $clog2(STAGES + 1);
    localparam logic [IDX_W-1:0] IDX_DEC  = IDX_W'(STAGES - 1);
    localparam logic [IDX_W-1:0] IDX_BODY = IDX_W'(STAGES);

    typedef struct packed {
        beat_t [STAGES-1:0] pipe;
        logic [IDX_W-1:0]   idx;
        logic               fr_drop;
        logic               req;
        logic [15:0]        quanta;
        logic [31:0]        addr_lo;
        logic [15:0]        addr_hi;
        logic               proc_en;
        logic               fwd_en;
        logic               tx_en;
    } state_t;

    state_t state_d, state_q;

    logic        c_pause, c_hit, c_full;
    logic [15:0] c_quanta;
    logic        p_drop, p_req;

    pfx_classify u_cls (
        .hdr0       (state_q.pipe[1].data[47:0]),
        .hdr1       (state_q.pipe[0].data[63:32]),
        .hdr2       (s_data[15:0]),
        .hdr2_keep1 (s_keep[1]),
        .match_addr ({state_q.addr_hi, state_q.addr_lo}),
        .is_pause   (c_pause),
        .addr_hit   (c_hit),
        .full_hdr   (c_full),
        .quanta     (c_quanta)
    );

    pfx_policy u_pol (
        .is_pause (c_pause),
        .addr_hit (c_hit),
        .full_hdr (c_full),
        .proc_en  (state_q.proc_en),
        .fwd_en   (state_q.fwd_en),
        .tx_en    (state_q.tx_en),
        .drop     (p_drop),
        .req      (p_req)
    );

    always_comb begin
        logic decide;
        state_d     = state_q;
        state_d.req = 1'b0;
        decide      = s_valid && (state_q.idx == IDX_DEC);

        state_d.pipe[0].valid = s_valid;
        state_d.pipe[0].last  = s_last;
        state_d.pipe[0].keep  = s_keep;
        state_d.pipe[0].data  = s_data;
        state_d.pipe[0].drop  = s_valid && (state_q.idx == IDX_BODY) && state_q.fr_drop;
        for (int i = 1; i < STAGES; i++) begin
            state_d.pipe[i] = state_q.pipe[i-1];
        end

        if (decide) begin
            for (int i = 0; i < STAGES; i++) begin
                state_d.pipe[i].drop = p_drop;
            end
            state_d.fr_drop = p_drop;
            state_d.req     = p_req;
            if (p_req) begin
                state_d.quanta = c_quanta;
            end
        end

        if (s_valid) begin
            if (s_last) begin
                state_d.idx = '0;
            end else if (state_q.idx != IDX_BODY) begin
                state_d.idx = state_q.idx + 1'b1;
            end
        end

        if (cfg_we) begin
            case (cfg_sel_e'(cfg_sel))
                SEL_ADDR_LO: state_d.addr_lo = cfg_wdata;
                SEL_ADDR_HI: state_d.addr_hi = cfg_wdata[15:0];
                SEL_CTRL: begin
                    state_d.proc_en = cfg_wdata[0];
                    state_d.fwd_en  = cfg_wdata[1];
                    state_d.tx_en   = cfg_wdata[2];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q         <= '0;
            state_q.addr_lo <= ADDR_RST[31:0];
            state_q.addr_hi <= ADDR_RST[47:32];
            state_q.proc_en <= 1'b1;
            state_q.fwd_en  <= 1'b0;
            state_q.tx_en   <= 1'b1;
        end else begin
            state_q <= state_d;
        end
    end

    assign m_valid      = state_q.pipe[LAST_ST].valid && !state_q.pipe[LAST_ST].drop;
    assign m_data       = state_q.pipe[LAST_ST].data;
    assign m_keep       = state_q.pipe[LAST_ST].keep;
    assign m_last       = state_q.pipe[LAST_ST].last;
    assign pause_req    = state_q.req;
    assign pause_quanta = state_q.quanta;
endmodule

// File: rtl/pfx_checker.sv
module pfx_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        s_valid,
    input logic [63:0] s_data,
    input logic        s_last,
    input logic        m_valid,
    input logic [63:0] m_data,
    input logic        m_last,
    input logic        pause_req,
    input logic        proc_en,
    input logic        fwd_en,
    input logic        tx_en
);
    // R6: a request lasts exactly one cycle
    assert_req_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pause_req |=> !pause_req);

    // R6: a request follows an accepted beat
    assert_req_beat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pause_req |-> $past(s_valid));

    // R5 and R9: a request needs both processing and transmit response enabled
    assert_req_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pause_req |-> ($past(proc_en) && $past(tx_en)));

    // R11: output beats are input beats three cycles later
    assert_delay_R11: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> ($past(s_valid, 3) && m_data == $past(s_data, 3) && m_last == $past(s_last, 3)));

    // R4: control word after reset
    assert_ctrl_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (proc_en && !fwd_en && tx_en));
endmodule

bind pfx_top pfx_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .s_valid   (s_valid),
    .s_data    (s_data),
    .s_last    (s_last),
    .m_valid   (m_valid),
    .m_data    (m_data),
    .m_last    (m_last),
    .pause_req (pause_req),
    .proc_en   (state_q.proc_en),
    .fwd_en    (state_q.fwd_en),
    .tx_en     (state_q.tx_en)
);

// File: tb/sim_pfx_top.sv
module sim_pfx_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        s_valid = 1'b0;
    logic [63:0] s_data = '0;
    logic [7:0]  s_keep = '0;
    logic        s_last = 1'b0;
    logic        m_valid, m_last, pause_req;
    logic [63:0] m_data;
    logic [7:0]  m_keep;
    logic [15:0] pause_quanta;

    int errors = 0;
    int checks = 0;
    int obs_beats = 0;
    int obs_req = 0;
    logic [63:0] obs_sum = '0;
    logic req_hit = 1'b0;
    bit done = 1'b0;

    localparam logic [47:0] MCAST = 48'h0180C2000001;
    localparam logic [47:0] UNI   = 48'h112233445566;
    localparam logic [47:0] OTHER = 48'h02AABBCCDDEE;

    always #2 clk = ~clk;

    pfx_top u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .s_valid(s_valid), .s_data(s_data), .s_keep(s_keep), .s_last(s_last),
        .m_valid(m_valid), .m_data(m_data), .m_keep(m_keep), .m_last(m_last),
        .pause_req(pause_req), .pause_quanta(pause_quanta)
    );

    always @(negedge clk) begin
        if (rst_n && m_valid) begin
            obs_beats++;
            obs_sum = obs_sum + m_data;
        end
        if (rst_n && pause_req) obs_req++;
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_obs();
        obs_beats = 0;
        obs_req = 0;
        obs_sum = '0;
    endtask

    task automatic flush();
        repeat (6) @(negedge clk);
    endtask

    task automatic write_reg(input logic [1:0] sel, input logic [31:0] val);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Caller is at a negedge. Sends nbeats contiguous beats.
    task automatic send_frame(input logic [47:0] da, input logic [15:0] etype, input logic [15:0] opc,
                              input logic [15:0] qv, input int nbeats, input logic [7:0] lkeep,
                              input bit gap, output logic [63:0] fsum);
        logic [7:0] by [64];
        fsum = '0;
        req_hit = 1'b0;
        for (int k = 0; k < 64; k++) by[k] = 8'(k * 13 + 5);
        for (int k = 0; k < 6; k++) by[k] = da[47-8*k -: 8];
        by[12] = etype[15:8]; by[13] = etype[7:0];
        by[14] = opc[15:8];   by[15] = opc[7:0];
        by[16] = qv[15:8];    by[17] = qv[7:0];
        for (int i = 0; i < nbeats; i++) begin
            s_valid = 1'b1;
            for (int j = 0; j < 8; j++) s_data[8*j +: 8] = by[8*i + j];
            s_last = (i == nbeats - 1);
            s_keep = (i == nbeats - 1) ? lkeep : 8'hFF;
            fsum = fsum + s_data;
            @(negedge clk);
            if (i == 2) req_hit = pause_req;
        end
        if (gap) begin
            s_valid = 1'b0; s_last = 1'b0;
        end
    endtask

    task automatic expect_frame(input string tag, input bit fwd, input bit req, input int nb,
                                input logic [63:0] fs, input logic [15:0] qv);
        flush();
        check(obs_beats == (fwd ? nb : 0), tag, obs_beats, fwd ? nb : 0);
        if (fwd) check(obs_sum == fs, tag, obs_sum, fs);
        check(obs_req == (req ? 1 : 0), tag, obs_req, req ? 1 : 0);
        if (req) begin
            check(req_hit == 1'b1, tag, req_hit, 1);
            check(pause_quanta == qv, tag, pause_quanta, qv);
        end
        clear_obs();
    endtask

    task automatic t_reset();
        check(m_valid == 1'b0, "R4 reset m_valid", m_valid, 0);
        check(pause_req == 1'b0, "R4 reset pause_req", pause_req, 0);
    endtask

    task automatic t_defaults();
        logic [63:0] fs;
        // R4 defaults + R3 multicast: dropped, request raised
        send_frame(MCAST, 16'h8808, 16'h0001, 16'h1234, 5, 8'h0F, 1, fs);
        expect_frame("R3 R4 R6 mcast default", 0, 1, 5, fs, 16'h1234);
    endtask

    task automatic t_unicast();
        logic [63:0] fs;
        write_reg(2'd0, UNI[31:0]);
        write_reg(2'd1, {16'h0, UNI[47:32]});
        send_frame(UNI, 16'h8808, 16'h0001, 16'hBEEF, 4, 8'hFF, 1, fs);
        expect_frame("R2 programmed unicast", 0, 1, 4, fs, 16'hBEEF);
        send_frame(OTHER, 16'h8808, 16'h0001, 16'h0F0F, 4, 8'hFF, 1, fs);
        expect_frame("R8 non-matching pause", 1, 0, 4, fs, 0);
    endtask

    task automatic t_not_pause();
        logic [63:0] fs;
        send_frame(UNI, 16'h0800, 16'h0001, 16'h0011, 6, 8'h3F, 1, fs);
        expect_frame("R1 other type", 1, 0, 6, fs, 0);
        send_frame(MCAST, 16'h8808, 16'h0101, 16'h0022, 4, 8'hFF, 1, fs);
        expect_frame("R1 other opcode", 1, 0, 4, fs, 0);
    endtask

    task automatic t_passthrough();
        logic [63:0] fs;
        write_reg(2'd2, 32'h7);
        send_frame(UNI, 16'h8808, 16'h0001, 16'h4321, 5, 8'h01, 1, fs);
        expect_frame("R7 pass-through forwards", 1, 1, 5, fs, 16'h4321);
        write_reg(2'd2, 32'h5);
        send_frame(UNI, 16'h8808, 16'h0001, 16'h5555, 3, 8'hFF, 1, fs);
        expect_frame("R7 no pass-through drops", 0, 1, 3, fs, 16'h5555);
    endtask

    task automatic t_proc_off();
        logic [63:0] fs;
        write_reg(2'd2, 32'h6);
        send_frame(MCAST, 16'h8808, 16'h0001, 16'h0777, 4, 8'hFF, 1, fs);
        expect_frame("R5 processing off drops", 0, 0, 4, fs, 0);
        check(pause_quanta == 16'h5555, "R5 quanta untouched", pause_quanta, 16'h5555);
    endtask

    task automatic t_tx_off();
        logic [63:0] fs;
        write_reg(2'd2, 32'h1);
        send_frame(UNI, 16'h8808, 16'h0001, 16'h0999, 4, 8'hFF, 1, fs);
        expect_frame("R9 tx response off", 0, 0, 4, fs, 0);
        write_reg(2'd2, 32'h3);
        send_frame(UNI, 16'h8808, 16'h0001, 16'h0AAA, 4, 8'hFF, 1, fs);
        expect_frame("R9 tx off with pass-through", 1, 0, 4, fs, 0);
        write_reg(2'd2, 32'h5);
    endtask

    task automatic t_short();
        logic [63:0] fs;
        send_frame(UNI, 16'h8808, 16'h0001, 16'h0101, 2, 8'hFF, 1, fs);
        expect_frame("R10 two-beat pause header", 1, 0, 2, fs, 0);
        send_frame(UNI, 16'h8808, 16'h0001, 16'h0202, 3, 8'h01, 1, fs);
        expect_frame("R10 quanta cut", 1, 0, 3, fs, 0);
        send_frame(MCAST, 16'h8808, 16'h0001, 16'h0303, 1, 8'h3F, 1, fs);
        expect_frame("R10 one-beat frame", 1, 0, 1, fs, 0);
    endtask

    task automatic t_latency();
        s_valid = 1'b1; s_data = 64'hA5A5_0123_4567_89AB; s_keep = 8'h7F; s_last = 1'b1;
        @(negedge clk);
        s_valid = 1'b0; s_last = 1'b0;
        check(m_valid == 1'b0, "R11 latency cycle 1", m_valid, 0);
        @(negedge clk);
        check(m_valid == 1'b0, "R11 latency cycle 2", m_valid, 0);
        @(negedge clk);
        check(m_valid == 1'b1, "R11 latency cycle 3", m_valid, 1);
        check(m_data == 64'hA5A5_0123_4567_89AB, "R11 data", m_data, 64'hA5A5_0123_4567_89AB);
        check(m_keep == 8'h7F && m_last, "R11 keep/last", {m_keep, 7'b0, m_last}, {8'h7F, 8'h01});
        flush();
        clear_obs();
    endtask

    task automatic t_chain();
        logic [63:0] fa, fb, fc;
        send_frame(OTHER, 16'h0800, 16'h0000, 16'h0000, 1, 8'hFF, 0, fa);
        send_frame(MCAST, 16'h8808, 16'h0001, 16'h0C0C, 4, 8'hFF, 0, fb);
        send_frame(UNI, 16'h0806, 16'h0000, 16'h0000, 2, 8'h0F, 1, fc);
        flush();
        check(obs_beats == 3, "R11 chained beats", obs_beats, 3);
        check(obs_sum == fa + fc, "R11 chained data", obs_sum, fa + fc);
        check(obs_req == 1, "R6 chained request", obs_req, 1);
        check(pause_quanta == 16'h0C0C, "R6 chained quanta", pause_quanta, 16'h0C0C);
        clear_obs();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        clear_obs();
        t_defaults();
        t_unicast();
        t_not_pause();
        t_passthrough();
        t_proc_off();
        t_tx_off();
        t_short();
        t_latency();
        t_chain();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule